// File: doc/BRIEF.md
# MII Management PHY Register Model

This block stands in for the management side of an Ethernet PHY. It holds an internal bank of emulated PHY registers and turns host writes to a MAC's MII address register into one-step read or write transactions on that bank. No serial MDIO waveform is produced. An access completes on the clock edge that accepts the address write, so the start bit never reads back as set.

The host register bus writes either the address register or the data register. A single select pin picks the target, and the host may issue one write per cycle. The block has no back-pressure: every strobed write is taken on that edge, so the bus needs no valid/ready pairing. Both registers can be read back at all times on plain output pins.

A link input models the cable state. Its edges set or clear the link-up and autonegotiation-complete flags of PHY 0. A synchronous MAC software reset clears the two MAC-side registers and leaves the PHY bank as it is.

Top module: `mii_mgmt_phy_model`

## Requirements
- R1: After the hardware reset both readback registers are 0. PHY 0 holds: register 0 = 0x1140, register 1 = 0x790D, register 2 = 0x0362, register 3 = 0x5E6A, register 7 = 0x2001, register 15 = 0x3000. Every other register of every PHY is 0.
- R2: An address-register write stores the written value with bit 0 forced to 0. Bit 0 is start/busy, bit 1 is write, bits [10:6] select the register and bits [15:11] select the PHY. The stored value is visible on the cycle after the write.
- R3: An address-register write with bit 0 clear starts no transaction: the data register and the PHY bank stay unchanged.
- R4: An address write with bits 0 and 1 both set copies the data register's bits [15:0] into the selected register of the selected PHY.
- R5: An address write with bit 0 set and bit 1 clear loads the selected PHY register into data register bits [15:0] and zero into bits [31:16].
- R6: A write transaction to register 0 stores the value with bits 15 and 9 cleared.
- R7: A write transaction to register 0 whose (stripped) value has bit 12 set, while bit 5 of register 1 of the same PHY is 0, sets that bit 5 and forces PHY 0 register 5 to 0x0000. If that bit 5 is already 1, register 5 is left alone.
- R8: A rising edge on the link input sets bits 2 and 5 of PHY 0 register 1. A falling edge clears both bits. A steady level has no effect. A link edge wins over a transaction to the same bits in the same cycle.
- R9: The software reset clears the address and data registers on the next edge, overrides any host write in the same cycle, and leaves the PHY bank unchanged.
- R10: A data-register write stores all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sw_rst | input | 1 | Synchronous MAC software reset (MAC-side registers only) |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_wr_sel | input | 1 | 0 = address register, 1 = data register |
| reg_wr_data | input | 32 | Host write value |
| link_up | input | 1 | Cable link state |
| mii_addr_q | output | 32 | Address register readback (bit 0 always 0) |
| mii_data_q | output | 32 | Data register readback |

## Verification
Directed sequences cover the reset image, the stripping of reset and restart bits in the control register, and both outcomes of the autonegotiation-enable rule: one where the complete flag starts clear, so the partner-ability register is zeroed, and one where it is already set, so that register is kept. Link toggling is checked both as edges and as a steady high level under a host write. The steady case separates edge-driven behaviour from level-driven behaviour. A software reset issued together with a write transaction shows that the bank is isolated from it. Seeded random traffic then mixes writes, reads, address writes without start, data writes and link edges across all PHY and register indices. A bench model predicts every readback, which catches wrong field positions and wrong side-effect ordering.

// File: rtl/mii_pkg.sv
package mii_pkg;

  localparam int unsigned HOST_W  = 32;
  localparam int unsigned PHY_W   = 16;
  localparam int unsigned FIELD_W = 5;

  // address register layout (decoded by software drivers)
  localparam int unsigned ADDR_GO_BIT  = 0;
  localparam int unsigned ADDR_WR_BIT  = 1;
  localparam int unsigned ADDR_REG_LSB = 6;
  localparam int unsigned ADDR_PHY_LSB = 11;

  // PHY register indices with side effects
  localparam logic [FIELD_W-1:0] IDX_CTL  = 5'd0;
  localparam logic [FIELD_W-1:0] IDX_STS  = 5'd1;
  localparam logic [FIELD_W-1:0] IDX_PEER = 5'd5;

  // bit positions inside those registers
  localparam int unsigned CTL_SELF_RST  = 15;
  localparam int unsigned CTL_AN_ENABLE = 12;
  localparam int unsigned CTL_AN_REDO   = 9;
  localparam int unsigned STS_LINK      = 2;
  localparam int unsigned STS_AN_DONE   = 5;

  localparam logic [PHY_W-1:0] CTL_STRIP_MASK =
      (16'h1 << CTL_SELF_RST) | (16'h1 << CTL_AN_REDO);

  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef struct packed {
    logic               go;
    logic               is_write;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
  } mii_cmd_t;

  // power-on image of the first PHY; others start cleared
  function automatic logic [PHY_W-1:0] phy0_reset_value(input int unsigned idx);
    logic [PHY_W-1:0] v;
    case (idx)
      0:       v = 16'h1140;
      1:       v = 16'h790D;
      2:       v = 16'h0362;
      3:       v = 16'h5E6A;
      7:       v = 16'h2001;
      15:      v = 16'h3000;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mii_cmd_decode.sv
module mii_cmd_decode
  import mii_pkg::*;
(
  input  logic              host_wr_en,
  input  logic              host_wr_sel,
  input  logic [PHY_W-1:0]  host_wr_low,
  input  logic              sw_rst,
  input  logic [PHY_W-1:0]  data_low,
  output mii_cmd_t          cmd,
  output logic [PHY_W-1:0]  payload,
  output logic              an_request
);

  logic addr_write;
  logic unused_bits;

  assign unused_bits = ^host_wr_low[ADDR_REG_LSB-1:ADDR_WR_BIT+1];
  assign addr_write  = host_wr_en && (host_wr_sel == SEL_ADDR) && !sw_rst;

  always_comb begin
    cmd.go       = addr_write && host_wr_low[ADDR_GO_BIT];
    cmd.is_write = host_wr_low[ADDR_WR_BIT];
    cmd.regn     = host_wr_low[ADDR_REG_LSB +: FIELD_W];
    cmd.phy      = host_wr_low[ADDR_PHY_LSB +: FIELD_W];
  end

  // self-clearing control bits never land in the bank
  always_comb begin
    payload = data_low;
    if (cmd.regn == IDX_CTL) payload = data_low & ~CTL_STRIP_MASK;
  end

  assign an_request = cmd.go && cmd.is_write && (cmd.regn == IDX_CTL)
                      && payload[CTL_AN_ENABLE];

endmodule

// File: rtl/mii_link_edge.sv
module mii_link_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic rise,
  output logic fall
);

  logic link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_in;
  end

  assign rise = link_in && !link_q;
  assign fall = !link_in && link_q;

endmodule

// File: rtl/mii_phy_regfile.sv
module mii_phy_regfile
  import mii_pkg::*;
#(
  parameter int unsigned PHY_IDX  = 0,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_idx,
  input  logic [PHY_W-1:0]   wr_data,
  input  logic [FIELD_W-1:0] rd_idx,
  input  logic               an_force,
  input  logic               lp_clear,
  input  logic               link_set,
  input  logic               link_clr,
  output logic [PHY_W-1:0]   rd_data,
  output logic               an_done
);

  logic [PHY_W-1:0] flat [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [PHY_W-1:0] RST_V =
        (PHY_IDX == 0) ? phy0_reset_value(r) : '0;
    localparam bit IS_STS  = (r == int'(IDX_STS));
    localparam bit IS_PEER = (r == int'(IDX_PEER));

    logic [PHY_W-1:0] q_r;
    logic [PHY_W-1:0] nxt;

    // order: host write, then autoneg side effects, then link edge
    always_comb begin
      nxt = q_r;
      if (wr_en && (wr_idx == FIELD_W'(r))) nxt = wr_data;
      if (IS_STS && an_force) nxt[STS_AN_DONE] = 1'b1;
      if (IS_PEER && lp_clear) nxt = '0;
      if (IS_STS && link_set) begin
        nxt[STS_LINK]    = 1'b1;
        nxt[STS_AN_DONE] = 1'b1;
      end
      if (IS_STS && link_clr) begin
        nxt[STS_LINK]    = 1'b0;
        nxt[STS_AN_DONE] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_V;
      else        q_r <= nxt;
    end

    assign flat[r] = q_r;
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rd_idx == FIELD_W'(r)) rd_data = flat[r];
    end
  end

  assign an_done = flat[IDX_STS][STS_AN_DONE];

  // R8
  link_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_set |=> (flat[IDX_STS][STS_LINK] && flat[IDX_STS][STS_AN_DONE]));

  // R8
  link_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_clr |=> (!flat[IDX_STS][STS_LINK] && !flat[IDX_STS][STS_AN_DONE]));

  // R6
  ctl_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_CTL) |=>
      (!flat[IDX_CTL][CTL_SELF_RST] && !flat[IDX_CTL][CTL_AN_REDO]));

  // R7
  peer_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_clear |=> (flat[IDX_PEER] == '0));

  // R7
  an_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (an_force && !link_clr) |=> flat[IDX_STS][STS_AN_DONE]);

endmodule

// File: rtl/mii_mgmt_phy_model.sv
module mii_mgmt_phy_model
  import mii_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 32,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst,
  input  logic        reg_wr_en,
  input  logic        reg_wr_sel,
  input  logic [31:0] reg_wr_data,
  input  logic        link_up,
  output logic [31:0] mii_addr_q,
  output logic [31:0] mii_data_q
);

  logic [HOST_W-1:0] addr_q;
  logic [HOST_W-1:0] data_q;

  mii_cmd_t          cmd;
  logic [PHY_W-1:0]  payload;
  logic              an_request;
  logic              an_fire;
  logic              link_rise;
  logic              link_fall;

  logic [PHY_W-1:0]  rd_all [NUM_PHYS];
  logic              an_all [NUM_PHYS];
  logic [PHY_W-1:0]  sel_rd;
  logic              sel_an;

  mii_cmd_decode u_decode (
    .host_wr_en  (reg_wr_en),
    .host_wr_sel (reg_wr_sel),
    .host_wr_low (reg_wr_data[PHY_W-1:0]),
    .sw_rst      (sw_rst),
    .data_low    (data_q[PHY_W-1:0]),
    .cmd         (cmd),
    .payload     (payload),
    .an_request  (an_request)
  );

  mii_link_edge u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_in (link_up),
    .rise    (link_rise),
    .fall    (link_fall)
  );

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phy
    localparam bit IS_FIRST = (p == 0);
    logic hit;
    assign hit = (cmd.phy == FIELD_W'(p));

    mii_phy_regfile #(
      .PHY_IDX  (p),
      .NUM_REGS (NUM_REGS)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmd.go && cmd.is_write && hit),
      .wr_idx   (cmd.regn),
      .wr_data  (payload),
      .rd_idx   (cmd.regn),
      .an_force (an_fire && hit),
      .lp_clear (IS_FIRST && an_fire),
      .link_set (IS_FIRST && link_rise),
      .link_clr (IS_FIRST && link_fall),
      .rd_data  (rd_all[p]),
      .an_done  (an_all[p])
    );
  end

  always_comb begin
    sel_rd = '0;
    sel_an = 1'b0;
    for (int p = 0; p < NUM_PHYS; p++) begin
      if (cmd.phy == FIELD_W'(p)) begin
        sel_rd = rd_all[p];
        sel_an = an_all[p];
      end
    end
  end

  assign an_fire = an_request && !sel_an;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (sw_rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_wr_sel == SEL_ADDR) begin
        addr_q <= {reg_wr_data[HOST_W-1:1], 1'b0};
        if (cmd.go && !cmd.is_write) data_q <= {{(HOST_W-PHY_W){1'b0}}, sel_rd};
      end else begin
        data_q <= reg_wr_data;
      end
    end
  end

  assign mii_addr_q = addr_q;
  assign mii_data_q = data_q;

  // R2
  addr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == SEL_ADDR && !sw_rst) |=>
      (mii_addr_q == {$past(reg_wr_data[31:1]), 1'b0}));

  // R3
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == SEL_ADDR && !reg_wr_data[0] && !sw_rst) |=>
      $stable(mii_data_q));

  // R5
  read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == SEL_ADDR && reg_wr_data[1:0] == 2'b01 && !sw_rst) |=>
      (mii_data_q[31:16] == 16'h0));

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (mii_addr_q == 32'h0 && mii_data_q == 32'h0));

  // R10
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_sel == SEL_DATA && !sw_rst) |=>
      (mii_data_q == $past(reg_wr_data)));

endmodule

// File: tb/mii_mgmt_phy_model_bench.sv
module mii_mgmt_phy_model_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_rst;
  logic        reg_wr_en;
  logic        reg_wr_sel;
  logic [31:0] reg_wr_data;
  logic        link_up;
  logic [31:0] mii_addr_q;
  logic [31:0] mii_data_q;

  always #4 clk = ~clk;

  mii_mgmt_phy_model u_mii_mgmt_phy_model (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .link_up     (link_up),
    .mii_addr_q  (mii_addr_q),
    .mii_data_q  (mii_data_q)
  );

  logic [15:0] mdl [32][32];
  logic [31:0] mdl_data;
  bit          link_prev;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 0;

  function automatic logic [15:0] rst_val(int p, int r);
    if (p != 0) return 16'h0;
    case (r)
      0: return 16'h1140;
      1: return 16'h790D;
      2: return 16'h0362;
      3: return 16'h5E6A;
      7: return 16'h2001;
      15: return 16'h3000;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [31:0] addr_word(int pa, int gr, bit wr, bit go);
    return {16'h0, pa[4:0], gr[4:0], 4'h0, wr, go};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(bit sel, logic [31:0] v);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (sel) mdl_data = v;
  endtask

  task automatic mdl_write(int pa, int gr, logic [15:0] d);
    logic [15:0] v;
    v = d;
    if (gr == 0) begin
      v = v & ~16'h8200;
      if (v[12] && !mdl[pa][1][5]) begin
        mdl[pa][1][5] = 1'b1;
        mdl[0][5] = 16'h0;
      end
    end
    mdl[pa][gr] = v;
  endtask

  task automatic txn_write(int pa, int gr, logic [31:0] d);
    host_wr(1'b1, d);
    host_wr(1'b0, addr_word(pa, gr, 1'b1, 1'b1));
    mdl_write(pa, gr, d[15:0]);
  endtask

  task automatic txn_read_chk(int pa, int gr, string req);
    host_wr(1'b0, addr_word(pa, gr, 1'b0, 1'b1));
    mdl_data = {16'h0, mdl[pa][gr]};
    chk(req, mii_data_q, mdl_data);
  endtask

  task automatic set_link(bit v);
    link_up = v;
    @(negedge clk);
    if (v && !link_prev) mdl[0][1] = mdl[0][1] | 16'h0024;
    if (!v && link_prev) mdl[0][1] = mdl[0][1] & ~16'h0024;
    link_prev = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = 1'b0;
    reg_wr_data = '0; link_up = 1'b0; link_prev = 1'b0; mdl_data = '0;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++) mdl[p][r] = rst_val(p, r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset image
    chk("R1 addr", mii_addr_q, 32'h0);
    chk("R1 data", mii_data_q, 32'h0);
    for (int r = 0; r < 32; r++) txn_read_chk(0, r, "R1 phy0");
    txn_read_chk(7, 0, "R1 phy7");
    txn_read_chk(31, 15, "R1 phy31");

    // R2 busy cleared, upper bits stored; R5 read fills upper zero
    host_wr(1'b0, 32'hDEAD0001);
    chk("R2 addr", mii_addr_q, 32'hDEAD0000);
    chk("R5 read", mii_data_q, 32'h00001140);

    // R10 and R3
    host_wr(1'b1, 32'h5555AAAA);
    chk("R10 data", mii_data_q, 32'h5555AAAA);
    host_wr(1'b0, addr_word(0, 2, 1'b1, 1'b0));
    chk("R3 data kept", mii_data_q, 32'h5555AAAA);
    chk("R3 addr", mii_addr_q, addr_word(0, 2, 1'b1, 1'b0));
    txn_read_chk(0, 2, "R3 bank kept");

    // R4 boundaries
    txn_write(2, 9, 32'hFFFF1357);
    txn_read_chk(2, 9, "R4 mid");
    txn_write(31, 31, 32'h0000BEEF);
    txn_read_chk(31, 31, "R4 top corner");
    txn_read_chk(30, 31, "R4 neighbour");

    // R8 link edges and steady level
    set_link(1'b1);
    txn_read_chk(0, 1, "R8 rise");
    set_link(1'b0);
    txn_read_chk(0, 1, "R8 fall");
    set_link(1'b1);
    txn_write(0, 1, 32'h0);
    repeat (3) @(negedge clk);
    txn_read_chk(0, 1, "R8 steady high");
    set_link(1'b0);
    txn_read_chk(0, 1, "R8 fall after write");

    // R6 strip plus R7 on PHY1
    txn_write(1, 0, 32'h0000FFFF);
    txn_read_chk(1, 0, "R6 strip");
    txn_read_chk(1, 1, "R7 phy1 done");

    // R7 on PHY0
    txn_write(0, 5, 32'h0000BEEF);
    txn_write(0, 0, 32'h00001200);
    txn_read_chk(0, 0, "R6 phy0");
    txn_read_chk(0, 1, "R7 done set");
    txn_read_chk(0, 5, "R7 peer zero");
    txn_write(0, 5, 32'h00001234);
    txn_write(0, 0, 32'h00001000);
    txn_read_chk(0, 5, "R7 peer kept");
    txn_write(4, 5, 32'h00007777);
    txn_write(4, 0, 32'h00000100);
    txn_read_chk(4, 1, "R7 no enable");
    txn_read_chk(0, 5, "R7 no enable peer");

    // R9 soft reset overrides a same-cycle write transaction
    host_wr(1'b1, 32'hCAFEF00D);
    sw_rst = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 1'b0;
    reg_wr_data = addr_word(3, 3, 1'b1, 1'b1);
    @(negedge clk);
    sw_rst = 1'b0; reg_wr_en = 1'b0; mdl_data = '0;
    chk("R9 addr", mii_addr_q, 32'h0);
    chk("R9 data", mii_data_q, 32'h0);
    txn_read_chk(3, 3, "R9 bank kept");
    txn_read_chk(0, 2, "R9 id kept");

    // seeded random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      int op;
      int pa;
      int gr;
      logic [31:0] v;
      op = $urandom_range(0, 9);
      pa = ($urandom_range(0, 1) != 0) ? $urandom_range(0, 3) : $urandom_range(0, 31);
      gr = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 5) : $urandom_range(0, 31);
      v  = $urandom;
      case (op)
        0, 1, 2, 3: txn_write(pa, gr, v);
        4, 5, 6:    txn_read_chk(pa, gr, "R4 random readback");
        7:          set_link(!link_prev);
        8: begin
          host_wr(1'b1, v);
          chk("R10 random data", mii_data_q, v);
        end
        default: begin
          host_wr(1'b0, v & 32'hFFFF_FFFE);
          chk("R3 random idle", mii_data_q, mdl_data);
          chk("R2 random addr", mii_addr_q, v & 32'hFFFF_FFFE);
        end
      endcase
    end
    for (int r = 0; r < 8; r++) txn_read_chk(0, r, "R8 final phy0");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule